// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair

This block sits between a host register interface and the serial shifters of a 16550-style UART and holds one byte queue in each direction. The host pushes characters for transmission with a write strobe and pulls received characters with a read strobe. The line side pops the transmit queue to load the transmit shifter and pushes each character the receive shifter completes. A control write sets the queue mode, the trigger levels and a DMA mode select, and can flush either queue. A status read returns the live occupancy of both queues, idle indications and two sticky error flags.

Both queues are 32 entries deep, and read data is shown at the head of each queue without a wait cycle. The transmit request signals that the transmit queue has room to be refilled. The receive request signals that enough characters have arrived to be worth collecting. The two trigger selects are encoded in opposite directions. With the queues disabled, each direction acts as a single holding register. Reads of the status word clear the sticky flags, but an error that happens in the same cycle keeps its flag set.

Top module: `uart_fifo_pair`

## Requirements
- R1: Bytes pushed by the host leave through the line-side transmit pop in the order written; `tx_level` and status bits 29:24 give the transmit queue count.
- R2: Bytes pushed by the line side leave through host reads in the order received; `rx_level` and status bits 21:16 give the receive queue count.
- R3: A host write while the transmit queue is full (32 entries, or 1 with queues disabled) is dropped and sets status bit 3. A status read clears bit 3 on the next cycle unless a new dropped write happens in the same cycle as the read.
- R4: A host read while the receive queue is empty leaves the queue unchanged and sets status bit 2. Bit 2 is cleared by a status read in the same way as bit 3, and a new empty read in the same cycle wins.
- R5: A control write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue, each on the next cycle. The other queue is left alone. Control readback always shows bits 1 and 2 as 0, and the other fields as written.
- R6: The transmit trigger select is control bits 5:4, with 0, 1, 2 and 3 giving marks 16, 8, 4 and 1. With queues enabled, `tx_req` is high while the transmit count is at or below the mark.
- R7: The receive trigger select is control bits 7:6, with 0, 1, 2 and 3 giving marks 1, 4, 8 and 16. With queues enabled, `rx_req` is high while the receive count is above the mark.
- R8: Control bit 0 enables the queues. When it is 0, each queue holds at most one byte, `tx_req` is high only when the transmit queue is empty, and `rx_req` is high only when the receive queue holds a byte.
- R9: Control bit 3 drives `dma_sel` from the cycle after the write.
- R10: Status bit 0 is 1 exactly when the transmit queue is empty and `tx_shift_busy` is low. Status bit 1 is 1 exactly when the receive queue is empty and `rx_shift_busy` is low.
- R11: After reset both queues are empty, both sticky flags are clear and the control fields are 0, so the queues start disabled.
- R12: A line-side pop from an empty transmit queue does nothing. A line-side push into a full receive queue is dropped. Neither sets a sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Push host byte into transmit queue |
| host_wr_data | input | 8 | Byte to transmit |
| host_rd_en | input | 1 | Pop receive queue head |
| host_rd_data | output | 8 | Receive queue head byte |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 8 | Control write value |
| ctl_rd_data | output | 8 | Control readback |
| stat_rd_en | input | 1 | Status read strobe, clears sticky flags |
| stat_rd_data | output | 32 | Status word |
| line_tx_pop | input | 1 | Transmit shifter takes the head byte |
| line_tx_data | output | 8 | Transmit queue head byte |
| line_rx_push | input | 1 | Receive shifter delivers a byte |
| line_rx_data | input | 8 | Received byte |
| tx_shift_busy | input | 1 | Transmit shifter is sending |
| rx_shift_busy | input | 1 | Receive shifter is assembling a character |
| tx_req | output | 1 | Transmit queue wants refilling |
| rx_req | output | 1 | Receive queue wants draining |
| tx_level | output | 6 | Transmit queue count |
| rx_level | output | 6 | Receive queue count |
| fifo_on | output | 1 | Queues enabled |
| dma_sel | output | 1 | DMA mode select |

## Verification
The properties assume that the status word is sampled as it stands in the cycle of the read strobe. They also assume that any error that keeps a flag set can only come from the host strobes. The line-side strobes are taken to need no guard, since the queues absorb them silently. The single-slot property holds only over stretches with no control write and counts already at most one, so mode switches with data still queued fall outside it. The stimulus drives every strobe only between clock edges and for exactly one cycle. It overlaps a status read with a new error only in the two scenarios that target that rule.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Control word bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_RXCLR = 1;
  localparam int CTL_TXCLR = 2;
  localparam int CTL_DMA   = 3;
  localparam int CTL_TXSEL = 4;
  localparam int CTL_RXSEL = 6;

  // Status word bit positions
  localparam int STS_TXIDLE = 0;
  localparam int STS_RXIDLE = 1;
  localparam int STS_UND    = 2;
  localparam int STS_OVR    = 3;
  localparam int STS_RXCNT  = 16;
  localparam int STS_TXCNT  = 24;
  localparam int STS_CNTW   = 6;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma;
    logic       en;
  } fifo_cfg_t;

  // Transmit mark: larger select means a lower refill point
  function automatic logic [4:0] tx_mark(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd16;
      2'd1:    return 5'd8;
      2'd2:    return 5'd4;
      default: return 5'd1;
    endcase
  endfunction

  // Receive mark: larger select means a deeper fill before request
  function automatic logic [4:0] rx_mark(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_slot,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign full    = single_slot ? (count_q != '0) : (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_next(rd_ptr_q);
      count_d = count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // Storage needs no reset; only the pointers define contents
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr_q] <= push_data;
  end

  assign head_data = mem[rd_ptr_q];
  assign count     = count_q;

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output fifo_cfg_t  cfg,
  output logic       rx_flush,
  output logic       tx_flush,
  output logic [7:0] rd_data
);

  fifo_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.en     = wr_data[CTL_EN];
      cfg_d.dma    = wr_data[CTL_DMA];
      cfg_d.tx_sel = wr_data[CTL_TXSEL +: 2];
      cfg_d.rx_sel = wr_data[CTL_RXSEL +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // Flush strobes act within the write cycle and are never stored
  assign rx_flush = wr_en & wr_data[CTL_RXCLR];
  assign tx_flush = wr_en & wr_data[CTL_TXCLR];

  always_comb begin
    rd_data                  = '0;
    rd_data[CTL_EN]          = cfg_q.en;
    rd_data[CTL_DMA]         = cfg_q.dma;
    rd_data[CTL_TXSEL +: 2]  = cfg_q.tx_sel;
    rd_data[CTL_RXSEL +: 2]  = cfg_q.rx_sel;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/uart_fifo_req.sv
module uart_fifo_req
  import uart_fifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          en,
  input  logic [1:0]    tx_sel,
  input  logic [1:0]    rx_sel,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          tx_empty,
  input  logic          rx_full,
  output logic          tx_req,
  output logic          rx_req
);

  logic [CW-1:0] tx_lim, rx_lim;

  assign tx_lim = CW'(tx_mark(tx_sel));
  assign rx_lim = CW'(rx_mark(rx_sel));

  // In single-slot mode the marks are meaningless; use occupancy directly
  assign tx_req = en ? (tx_count <= tx_lim) : tx_empty;
  assign rx_req = en ? (rx_count >  rx_lim) : rx_full;

endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_fifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          ovr_evt,
  input  logic          und_evt,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          tx_idle,
  input  logic          rx_idle,
  output logic [31:0]   word
);

  logic ovr_q, ovr_d;
  logic und_q, und_d;

  // A fresh event outranks the clear from a status read
  always_comb begin
    ovr_d = ovr_evt | (ovr_q & ~rd_en);
    und_d = und_evt | (und_q & ~rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      und_q <= und_d;
    end
  end

  always_comb begin
    word                          = '0;
    word[STS_TXIDLE]              = tx_idle;
    word[STS_RXIDLE]              = rx_idle;
    word[STS_UND]                 = und_q;
    word[STS_OVR]                 = ovr_q;
    word[STS_RXCNT +: STS_CNTW]   = STS_CNTW'(rx_count);
    word[STS_TXCNT +: STS_CNTW]   = STS_CNTW'(tx_count);
  end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int DEPTH = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_en,
  input  logic [DW-1:0] host_wr_data,
  input  logic          host_rd_en,
  output logic [DW-1:0] host_rd_data,
  input  logic          ctl_wr_en,
  input  logic [7:0]    ctl_wr_data,
  output logic [7:0]    ctl_rd_data,
  input  logic          stat_rd_en,
  output logic [31:0]   stat_rd_data,
  input  logic          line_tx_pop,
  output logic [DW-1:0] line_tx_data,
  input  logic          line_rx_push,
  input  logic [DW-1:0] line_rx_data,
  input  logic          tx_shift_busy,
  input  logic          rx_shift_busy,
  output logic          tx_req,
  output logic          rx_req,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          fifo_on,
  output logic          dma_sel
);

  fifo_cfg_t     cfg;
  logic          rx_flush, tx_flush;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;

  uart_fifo_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr_en),
    .wr_data  (ctl_wr_data),
    .cfg      (cfg),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .rd_data  (ctl_rd_data)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_slot (~cfg.en),
    .flush       (tx_flush),
    .push_req    (host_wr_en),
    .push_data   (host_wr_data),
    .pop_req     (line_tx_pop),
    .head_data   (line_tx_data),
    .count       (tx_cnt),
    .full        (tx_full),
    .empty       (tx_empty)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_slot (~cfg.en),
    .flush       (rx_flush),
    .push_req    (line_rx_push),
    .push_data   (line_rx_data),
    .pop_req     (host_rd_en),
    .head_data   (host_rd_data),
    .count       (rx_cnt),
    .full        (rx_full),
    .empty       (rx_empty)
  );

  uart_fifo_req #(.CW(CW)) u_req (
    .en       (cfg.en),
    .tx_sel   (cfg.tx_sel),
    .rx_sel   (cfg.rx_sel),
    .tx_count (tx_cnt),
    .rx_count (rx_cnt),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .tx_req   (tx_req),
    .rx_req   (rx_req)
  );

  uart_fifo_status #(.CW(CW)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (stat_rd_en),
    .ovr_evt  (host_wr_en & tx_full),
    .und_evt  (host_rd_en & rx_empty),
    .tx_count (tx_cnt),
    .rx_count (rx_cnt),
    .tx_idle  (tx_empty & ~tx_shift_busy),
    .rx_idle  (rx_empty & ~rx_shift_busy),
    .word     (stat_rd_data)
  );

  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;
  assign fifo_on  = cfg.en;
  assign dma_sel  = cfg.dma;

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr_en,
  input logic          host_rd_en,
  input logic          ctl_wr_en,
  input logic [7:0]    ctl_wr_data,
  input logic [7:0]    ctl_rd_data,
  input logic          stat_rd_en,
  input logic [31:0]   stat_rd_data,
  input logic          tx_shift_busy,
  input logic          rx_shift_busy,
  input logic          tx_req,
  input logic          rx_req,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          fifo_on,
  input logic          dma_sel
);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH) && rx_level <= CW'(DEPTH));

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && fifo_on && tx_level == CW'(DEPTH) |=> stat_rd_data[3]);

  p_ovr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_data[3] && !stat_rd_en |=> stat_rd_data[3]);

  p_ovr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_en && !host_wr_en |=> !stat_rd_data[3]);

  p_und_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en && rx_level == '0 |=> stat_rd_data[2]);

  p_und_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_en && !host_rd_en |=> !stat_rd_data[2]);

  p_rx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wr_data[1] |=> rx_level == '0);

  p_tx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wr_data[2] |=> tx_level == '0);

  p_flush_rdback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_data[2:1] == 2'b00);

  p_tx_req_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level == '0 |-> tx_req);

  p_rx_req_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == '0 |-> !rx_req);

  p_single_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on && !ctl_wr_en && tx_level <= CW'(1) && rx_level <= CW'(1)
    |=> tx_level <= CW'(1) && rx_level <= CW'(1));

  p_dma_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> dma_sel == $past(ctl_wr_data[3]));

  p_tx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_data[0] |-> tx_level == '0 && !tx_shift_busy);

  p_rx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_data[1] |-> rx_level == '0 && !rx_shift_busy);

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_wr_en    (host_wr_en),
  .host_rd_en    (host_rd_en),
  .ctl_wr_en     (ctl_wr_en),
  .ctl_wr_data   (ctl_wr_data),
  .ctl_rd_data   (ctl_rd_data),
  .stat_rd_en    (stat_rd_en),
  .stat_rd_data  (stat_rd_data),
  .tx_shift_busy (tx_shift_busy),
  .rx_shift_busy (rx_shift_busy),
  .tx_req        (tx_req),
  .rx_req        (rx_req),
  .tx_level      (tx_level),
  .rx_level      (rx_level),
  .fifo_on       (fifo_on),
  .dma_sel       (dma_sel)
);

// File: tb/sim_uart_fifo_pair.sv
module sim_uart_fifo_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [7:0]  host_wr_data;
  logic        host_rd_en;
  logic [7:0]  host_rd_data;
  logic        ctl_wr_en;
  logic [7:0]  ctl_wr_data;
  logic [7:0]  ctl_rd_data;
  logic        stat_rd_en;
  logic [31:0] stat_rd_data;
  logic        line_tx_pop;
  logic [7:0]  line_tx_data;
  logic        line_rx_push;
  logic [7:0]  line_rx_data;
  logic        tx_shift_busy;
  logic        rx_shift_busy;
  logic        tx_req;
  logic        rx_req;
  logic [5:0]  tx_level;
  logic [5:0]  rx_level;
  logic        fifo_on;
  logic        dma_sel;

  int n_chk = 0;
  int n_bad = 0;

  uart_fifo_pair u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_en    (host_wr_en),
    .host_wr_data  (host_wr_data),
    .host_rd_en    (host_rd_en),
    .host_rd_data  (host_rd_data),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_wr_data   (ctl_wr_data),
    .ctl_rd_data   (ctl_rd_data),
    .stat_rd_en    (stat_rd_en),
    .stat_rd_data  (stat_rd_data),
    .line_tx_pop   (line_tx_pop),
    .line_tx_data  (line_tx_data),
    .line_rx_push  (line_rx_push),
    .line_rx_data  (line_rx_data),
    .tx_shift_busy (tx_shift_busy),
    .rx_shift_busy (rx_shift_busy),
    .tx_req        (tx_req),
    .rx_req        (rx_req),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .fifo_on       (fifo_on),
    .dma_sel       (dma_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // All strobes rise and fall at falling edges, one cycle wide
  task automatic do_ctl(input logic [7:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] d);
    host_wr_en = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic do_lpush(input logic [7:0] d);
    line_rx_push = 1'b1; line_rx_data = d;
    @(negedge clk);
    line_rx_push = 1'b0;
  endtask

  task automatic do_lpop(output logic [7:0] d);
    line_tx_pop = 1'b1;
    #1 d = line_tx_data;
    @(negedge clk);
    line_tx_pop = 1'b0;
  endtask

  task automatic do_pop(output logic [7:0] d);
    host_rd_en = 1'b1;
    #1 d = host_rd_data;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  task automatic do_stat(output logic [31:0] v);
    stat_rd_en = 1'b1;
    #1 v = stat_rd_data;
    @(negedge clk);
    stat_rd_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11", "tx_level", 32'(tx_level), 0);
    chk("R11", "rx_level", 32'(rx_level), 0);
    chk("R11", "status", stat_rd_data, 32'h3);
    chk("R11", "ctl readback", 32'(ctl_rd_data), 0);
    chk("R11", "fifo_on", 32'(fifo_on), 0);
    chk("R11", "tx_req", 32'(tx_req), 1);
    chk("R11", "rx_req", 32'(rx_req), 0);
  endtask

  task automatic t_single_slot;
    logic [7:0] d; logic [31:0] s;
    do_push(8'hA1);
    do_push(8'hA2);
    chk("R8", "tx_level single slot", 32'(tx_level), 1);
    chk("R8", "tx_req holding byte", 32'(tx_req), 0);
    do_stat(s);
    chk("R3", "overrun in single slot", 32'(s[3]), 1);
    do_stat(s);
    chk("R3", "overrun cleared by read", 32'(s[3]), 0);
    do_lpop(d);
    chk("R8", "kept first byte", 32'(d), 32'hA1);
    chk("R8", "tx_req empty", 32'(tx_req), 1);
    chk("R8", "rx_req empty", 32'(rx_req), 0);
    do_lpush(8'hB1);
    do_lpush(8'hB2);
    chk("R8", "rx_level single slot", 32'(rx_level), 1);
    chk("R8", "rx_req holding byte", 32'(rx_req), 1);
    do_pop(d);
    chk("R8", "rx kept first byte", 32'(d), 32'hB1);
  endtask

  task automatic t_tx_order;
    logic [7:0] d; logic [31:0] s;
    do_ctl(8'h05);
    for (int i = 0; i < 5; i++) do_push(8'h10 + 8'(i));
    chk("R1", "tx_level", 32'(tx_level), 5);
    do_stat(s);
    chk("R1", "status tx count", 32'(s[29:24]), 5);
    for (int i = 0; i < 5; i++) begin
      do_lpop(d);
      chk("R1", "tx order", 32'(d), 32'h10 + 32'(i));
    end
    chk("R1", "tx_level drained", 32'(tx_level), 0);
  endtask

  task automatic t_rx_order;
    logic [7:0] d; logic [31:0] s;
    do_ctl(8'h03);
    for (int i = 0; i < 7; i++) do_lpush(8'hC0 + 8'(i));
    chk("R2", "rx_level", 32'(rx_level), 7);
    do_stat(s);
    chk("R2", "status rx count", 32'(s[21:16]), 7);
    for (int i = 0; i < 7; i++) begin
      do_pop(d);
      chk("R2", "rx order", 32'(d), 32'hC0 + 32'(i));
    end
  endtask

  task automatic t_tx_trig;
    int mark;
    for (int sel = 0; sel < 4; sel++) begin
      mark = (sel == 0) ? 16 : (sel == 1) ? 8 : (sel == 2) ? 4 : 1;
      do_ctl(8'(sel << 4) | 8'h05);
      for (int n = 0; n <= 17; n++) begin
        chk("R6", $sformatf("tx_req sel %0d count %0d", sel, n),
            32'(tx_req), (n <= mark) ? 1 : 0);
        do_push(8'(n));
      end
    end
  endtask

  task automatic t_rx_trig;
    int mark;
    for (int sel = 0; sel < 4; sel++) begin
      mark = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 16;
      do_ctl(8'(sel << 6) | 8'h03);
      for (int n = 0; n <= 17; n++) begin
        chk("R7", $sformatf("rx_req sel %0d count %0d", sel, n),
            32'(rx_req), (n > mark) ? 1 : 0);
        do_lpush(8'(n));
      end
    end
  endtask

  task automatic t_overrun;
    logic [7:0] d; logic [31:0] s;
    do_ctl(8'h05);
    for (int i = 0; i < 32; i++) do_push(8'(i));
    chk("R3", "tx full level", 32'(tx_level), 32);
    do_push(8'hEE);
    chk("R3", "dropped write", 32'(tx_level), 32);
    host_wr_en = 1'b1; host_wr_data = 8'hEF; stat_rd_en = 1'b1;
    #1 s = stat_rd_data;
    chk("R3", "flag seen during read", 32'(s[3]), 1);
    @(negedge clk);
    host_wr_en = 1'b0; stat_rd_en = 1'b0;
    do_stat(s);
    chk("R3", "new event beats clear", 32'(s[3]), 1);
    do_stat(s);
    chk("R3", "cleared", 32'(s[3]), 0);
    chk("R3", "no underrun side effect", 32'(s[2]), 0);
    for (int i = 0; i < 32; i++) begin
      do_lpop(d);
      chk("R3", "contents kept", 32'(d), 32'(i));
    end
  endtask

  task automatic t_underrun;
    logic [7:0] d; logic [31:0] s;
    do_ctl(8'h03);
    do_pop(d);
    chk("R4", "rx_level stays 0", 32'(rx_level), 0);
    do_stat(s);
    chk("R4", "underrun set", 32'(s[2]), 1);
    do_stat(s);
    chk("R4", "underrun cleared", 32'(s[2]), 0);
    do_pop(d);
    host_rd_en = 1'b1; stat_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0; stat_rd_en = 1'b0;
    do_stat(s);
    chk("R4", "new event beats clear", 32'(s[2]), 1);
    do_stat(s);
    chk("R4", "cleared after", 32'(s[2]), 0);
  endtask

  task automatic t_flush;
    logic [7:0] d;
    do_ctl(8'h67);
    for (int i = 0; i < 3; i++) do_push(8'h30 + 8'(i));
    for (int i = 0; i < 4; i++) do_lpush(8'h40 + 8'(i));
    do_ctl(8'h63);
    chk("R5", "rx flushed", 32'(rx_level), 0);
    chk("R5", "tx untouched", 32'(tx_level), 3);
    chk("R5", "ctl readback", 32'(ctl_rd_data), 32'h61);
    do_ctl(8'h65);
    chk("R5", "tx flushed", 32'(tx_level), 0);
    chk("R5", "ctl readback 2", 32'(ctl_rd_data), 32'h61);
    do_lpush(8'h55);
    do_pop(d);
    chk("R5", "rx usable after flush", 32'(d), 32'h55);
  endtask

  task automatic t_dma;
    do_ctl(8'h09);
    chk("R9", "dma_sel set", 32'(dma_sel), 1);
    chk("R9", "ctl readback", 32'(ctl_rd_data), 32'h09);
    do_ctl(8'h01);
    chk("R9", "dma_sel clear", 32'(dma_sel), 0);
  endtask

  task automatic t_line_ignore;
    logic [7:0] d; logic [31:0] s;
    do_ctl(8'h07);
    do_lpop(d);
    chk("R12", "tx pop on empty", 32'(tx_level), 0);
    do_push(8'h42);
    do_lpop(d);
    chk("R12", "tx head intact", 32'(d), 32'h42);
    for (int i = 0; i < 32; i++) do_lpush(8'h80 + 8'(i));
    do_lpush(8'hFF);
    chk("R12", "rx full push dropped", 32'(rx_level), 32);
    do_stat(s);
    chk("R12", "no sticky flags", 32'(s[3:2]), 0);
    do_pop(d);
    chk("R12", "rx head intact", 32'(d), 32'h80);
    do_ctl(8'h07);
  endtask

  task automatic t_idle;
    logic [31:0] s;
    do_ctl(8'h07);
    tx_shift_busy = 1'b1;
    #1 chk("R10", "tx busy not idle", 32'(stat_rd_data[0]), 0);
    tx_shift_busy = 1'b0;
    #1 chk("R10", "tx idle", 32'(stat_rd_data[0]), 1);
    @(negedge clk);
    do_push(8'h01);
    chk("R10", "tx holding not idle", 32'(stat_rd_data[0]), 0);
    rx_shift_busy = 1'b1;
    #1 chk("R10", "rx busy not idle", 32'(stat_rd_data[1]), 0);
    rx_shift_busy = 1'b0;
    @(negedge clk);
    do_lpush(8'h02);
    do_stat(s);
    chk("R10", "rx holding not idle", 32'(s[1:0]), 0);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    host_wr_en = 1'b0; host_wr_data = '0;
    host_rd_en = 1'b0;
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
    stat_rd_en = 1'b0;
    line_tx_pop = 1'b0;
    line_rx_push = 1'b0; line_rx_data = '0;
    tx_shift_busy = 1'b0; rx_shift_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_slot();
    t_tx_order();
    t_rx_order();
    t_tx_trig();
    t_rx_trig();
    t_overrun();
    t_underrun();
    t_flush();
    t_dma();
    t_line_ignore();
    t_idle();
    finish_run();
  end

endmodule